// File: doc/BRIEF.md
# Serial-Access Real-Time Clock with Alarm

This block is a real-time clock that a host reaches over a four-wire serial link, with this block as the slave. It keeps seconds, minutes and hours in BCD, advanced by a one-pulse-per-second input. It also holds day-of-week, date, month and year bytes, a three-byte alarm, a clock-control byte, an interrupt-control byte, a status byte and 32 bytes of scratch RAM.

Each select period opens with an address byte. Bit 7 of that byte marks the period as a write. Every later byte in the period is a data access at the current address, and the address steps forward after each one. Every location has a read address and a write address that differ by 0x80.

An interrupt output reports two sources: an alarm match on hours, minutes and seconds, and a periodic event chosen by a rate code. Reading the status byte shows the pending sources and clears them.

Top module: `spi_rtc`

## Requirements
- R1: A select period is the time `spiSel` is high. The link uses clock mode 0: the slave samples `spiMosi` on the rising edge of `spiSck`, changes `spiMiso` after the falling edge, and both directions send MSB first. The first byte of a period is the address, and its bit 7 = 1 makes every data byte of the period a write. While `spiSel` is low, `spiMiso` is 0.
- R2: After each data byte, bits 6..0 of the address increase by one, and bit 7 keeps the value from the address byte. A burst therefore walks through consecutive locations.
- R3: The 32 RAM bytes are read at 0x00–0x1F and written at 0x80–0x9F.
- R4: Seconds, minutes, hours, day of week, date, month and year are read at 0x20–0x26 and written at 0xA0–0xA6. Clock control is read at 0x31 and written at 0xB1. Interrupt control is read at 0x32 and written at 0xB2. The alarm seconds, minutes and hours are written at 0xA8–0xAA and cannot be read back. Any other read address returns 0x00.
- R5: The time counters advance on a `tick1Hz` pulse only while clock-control bit 7 is 1. Otherwise the pulse is ignored.
- R6: Seconds and minutes count in BCD and wrap from 0x59 to 0x00, carrying into the next field. In 24-hour mode (hours bit 7 = 0), hours wrap from 0x23 to 0x00, and the day of week then advances, wrapping from 0x07 to 0x01.
- R7: In 12-hour mode (hours bit 7 = 1), bit 5 is PM and bits 4..0 hold BCD 01–12. A carry into the hour at 11 goes to 12 and toggles PM. A carry at 12 goes to 01 with PM unchanged. The day of week advances when the 11 PM carry turns into 12 AM.
- R8: When seconds, minutes and hours become equal to the alarm bytes while interrupt-control bit 4 is 1, status bit 1 (alarm pending) is set. With bit 4 at 0, a match sets nothing.
- R9: Interrupt-control bits 3..0 select the periodic source: 1100 raises an event on each advancing tick, 1101 on each seconds wrap, and 1110 on each minutes wrap. Any other code raises no events. An event sets status bit 0 (periodic pending).
- R10: Status bit 6 is 1 while any pending bit is set, and `irqOut` follows it. A read of the status byte at 0x30 clears the pending bits, so `irqOut` falls unless a new event arrives in the same cycle.
- R11: After reset all registers and RAM hold 0x00 and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle pulse once per second |
| spiSel | input | 1 | Slave select, active high |
| spiSck | input | 1 | Serial clock from the host |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| irqOut | output | 1 | Interrupt request, high while a source is pending |

## Verification
The hardest state to reach is the set of carry chains that fire only at the end of an hour or a day: the 11 to 12 PM toggle, the PM-to-AM day advance, and the 23:59:59 day wrap. The bench reaches each one directly. It bursts a time one second before the boundary into the write addresses, then sends a single tick. Alarm and periodic pending bits are created the same way: a preset time sits just short of the alarm or of a wrap, one or two ticks follow, and a status read shows that the read clears the request.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Low seven bits of the location addresses (read = offset, write = offset | 0x80)
  localparam logic [6:0] OFF_SEC  = 7'h20;
  localparam logic [6:0] OFF_MIN  = 7'h21;
  localparam logic [6:0] OFF_HR   = 7'h22;
  localparam logic [6:0] OFF_DOW  = 7'h23;
  localparam logic [6:0] OFF_DATE = 7'h24;
  localparam logic [6:0] OFF_MON  = 7'h25;
  localparam logic [6:0] OFF_YR   = 7'h26;
  localparam logic [6:0] OFF_ASEC = 7'h28;
  localparam logic [6:0] OFF_AMIN = 7'h29;
  localparam logic [6:0] OFF_AHR  = 7'h2A;
  localparam logic [6:0] OFF_STAT = 7'h30;
  localparam logic [6:0] OFF_CLK  = 7'h31;
  localparam logic [6:0] OFF_INT  = 7'h32;

  // Periodic rate codes
  localparam logic [3:0] RATE_SEC  = 4'hC;
  localparam logic [3:0] RATE_MIN  = 4'hD;
  localparam logic [3:0] RATE_HOUR = 4'hE;

  // Strobes from the serial control to the register datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic [6:0] wrAddr;
    logic [6:0] rdAddr;
    logic [7:0] wrData;
  } rtcStrobe_t;

  // One BCD count step of a two-digit byte
  function automatic logic [7:0] bcdStep(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSel,
  input  logic       spiSck,
  input  logic       spiMosi,
  input  logic [7:0] rdData,
  output logic       spiMiso,
  output rtcStrobe_t stb
);

  localparam int BIT_W = 3;

  logic [SYNC_STAGES-1:0] selSync, sckSync, mosiSync;
  logic selS, sckS, mosiS, sckQ;
  logic sckRise, sckFall;
  logic [BIT_W-1:0] bitCnt;
  logic [7:0] rxShift, rxNext, txReg;
  logic       haveAddr, isWrite, loadPend;
  logic [6:0] addrPtr;
  logic       wrEnQ;
  logic [6:0] wrAddrQ;
  logic [7:0] wrDataQ;

  // Input synchronizers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selSync  <= '0;
      sckSync  <= '0;
      mosiSync <= '0;
    end else begin
      selSync  <= {selSync[SYNC_STAGES-2:0], spiSel};
      sckSync  <= {sckSync[SYNC_STAGES-2:0], spiSck};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
    end
  end

  assign selS    = selSync[SYNC_STAGES-1];
  assign sckS    = sckSync[SYNC_STAGES-1];
  assign mosiS   = mosiSync[SYNC_STAGES-1];
  assign sckRise = sckS & ~sckQ;
  assign sckFall = ~sckS & sckQ;
  assign rxNext  = {rxShift[6:0], mosiS};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      bitCnt   <= '0;
      rxShift  <= '0;
      txReg    <= '0;
      haveAddr <= 1'b0;
      isWrite  <= 1'b0;
      loadPend <= 1'b0;
      addrPtr  <= '0;
      wrEnQ    <= 1'b0;
      wrAddrQ  <= '0;
      wrDataQ  <= '0;
    end else begin
      sckQ  <= sckS;
      wrEnQ <= 1'b0;
      if (!selS) begin
        bitCnt   <= '0;
        haveAddr <= 1'b0;
        loadPend <= 1'b0;
        txReg    <= '0;
      end else begin
        if (sckRise) begin
          rxShift <= rxNext;
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(7)) begin
            if (!haveAddr) begin
              haveAddr <= 1'b1;
              isWrite  <= rxNext[7];
              addrPtr  <= rxNext[6:0];
              loadPend <= ~rxNext[7];
            end else begin
              addrPtr <= addrPtr + 7'd1;
              if (isWrite) begin
                wrEnQ   <= 1'b1;
                wrAddrQ <= addrPtr;
                wrDataQ <= rxNext;
              end else begin
                loadPend <= 1'b1;
              end
            end
          end
        end
        if (sckFall) begin
          if (loadPend) begin
            txReg    <= rdData;
            loadPend <= 1'b0;
          end else begin
            txReg <= {txReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign spiMiso    = txReg[7];
  assign stb.wrEn   = wrEnQ;
  assign stb.wrAddr = wrAddrQ;
  assign stb.wrData = wrDataQ;
  assign stb.rdAddr = addrPtr;
  assign stb.rdEn   = selS & sckFall & loadPend;

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selS |=> !spiMiso);

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |=> !wrEnQ);

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdEn && isWrite && haveAddr));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int RAM_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1Hz,
  input  rtcStrobe_t stb,
  output logic [7:0] rdData,
  output logic       irqOut
);

  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] secR, minR, hrR, dowR, dateR, monR, yrR;
  logic [7:0] almSec, almMin, almHr, clkCtrl, intCtrl;
  logic       alarmFlag, perFlag, matchQ;

  logic       advance, secWrap, minWrap, dayWrap;
  logic [7:0] secN, minN, hrN, dowN, hrStep;
  logic       matchNow, setAlarm, perEvent, clrStat;
  logic       wrRam, rdRam;

  assign advance = tick1Hz & clkCtrl[7] & ~stb.wrEn;
  assign secWrap = (secR == 8'h59);
  assign minWrap = (minR == 8'h59);
  assign hrStep  = bcdStep({3'b000, hrR[4:0]});

  always_comb begin
    secN = secWrap ? 8'h00 : bcdStep(secR);
    minN = minWrap ? 8'h00 : bcdStep(minR);
    dayWrap = 1'b0;
    if (hrR[7]) begin
      if (hrR[4:0] == 5'h11) begin
        hrN     = {hrR[7:6], ~hrR[5], 5'h12};
        dayWrap = hrR[5];
      end else if (hrR[4:0] == 5'h12) begin
        hrN = {hrR[7:5], 5'h01};
      end else begin
        hrN = {hrR[7:5], hrStep[4:0]};
      end
    end else begin
      if (hrR[5:0] == 6'h23) begin
        hrN     = 8'h00;
        dayWrap = 1'b1;
      end else begin
        hrN = bcdStep(hrR);
      end
    end
    dowN = (dowR == 8'h07) ? 8'h01 : bcdStep(dowR);
  end

  always_comb begin
    case (intCtrl[3:0])
      RATE_SEC:  perEvent = advance;
      RATE_MIN:  perEvent = advance & secWrap;
      RATE_HOUR: perEvent = advance & secWrap & minWrap;
      default:   perEvent = 1'b0;
    endcase
  end

  assign matchNow = (secR == almSec) && (minR == almMin) && (hrR == almHr);
  assign setAlarm = matchNow & ~matchQ & intCtrl[4];
  assign clrStat  = stb.rdEn && (stb.rdAddr == OFF_STAT);
  assign wrRam    = stb.wrEn && (stb.wrAddr[6:RAM_AW] == '0);
  assign rdRam    = (stb.rdAddr[6:RAM_AW] == '0);

  // Scratch RAM
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (wrRam) begin
      ram[stb.wrAddr[RAM_AW-1:0]] <= stb.wrData;
    end
  end

  // Time counters and control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR <= '0; minR <= '0; hrR <= '0; dowR <= '0;
      dateR <= '0; monR <= '0; yrR <= '0;
      almSec <= '0; almMin <= '0; almHr <= '0;
      clkCtrl <= '0; intCtrl <= '0;
    end else if (stb.wrEn) begin
      case (stb.wrAddr)
        OFF_SEC:  secR    <= stb.wrData;
        OFF_MIN:  minR    <= stb.wrData;
        OFF_HR:   hrR     <= stb.wrData;
        OFF_DOW:  dowR    <= stb.wrData;
        OFF_DATE: dateR   <= stb.wrData;
        OFF_MON:  monR    <= stb.wrData;
        OFF_YR:   yrR     <= stb.wrData;
        OFF_ASEC: almSec  <= stb.wrData;
        OFF_AMIN: almMin  <= stb.wrData;
        OFF_AHR:  almHr   <= stb.wrData;
        OFF_CLK:  clkCtrl <= stb.wrData;
        OFF_INT:  intCtrl <= stb.wrData;
        default: ;
      endcase
    end else if (advance) begin
      secR <= secN;
      if (secWrap) begin
        minR <= minN;
        if (minWrap) begin
          hrR <= hrN;
          if (dayWrap) dowR <= dowN;
        end
      end
    end
  end

  // Pending flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      perFlag   <= 1'b0;
      matchQ    <= 1'b0;
    end else begin
      matchQ    <= matchNow;
      alarmFlag <= setAlarm | (alarmFlag & ~clrStat);
      perFlag   <= perEvent | (perFlag & ~clrStat);
    end
  end

  assign irqOut = alarmFlag | perFlag;

  always_comb begin
    rdData = 8'h00;
    if (rdRam) begin
      rdData = ram[stb.rdAddr[RAM_AW-1:0]];
    end else begin
      case (stb.rdAddr)
        OFF_SEC:  rdData = secR;
        OFF_MIN:  rdData = minR;
        OFF_HR:   rdData = hrR;
        OFF_DOW:  rdData = dowR;
        OFF_DATE: rdData = dateR;
        OFF_MON:  rdData = monR;
        OFF_YR:   rdData = yrR;
        OFF_STAT: rdData = {1'b0, irqOut, 4'b0000, alarmFlag, perFlag};
        OFF_CLK:  rdData = clkCtrl;
        OFF_INT:  rdData = intCtrl;
        default:  rdData = 8'h00;
      endcase
    end
  end

  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && secWrap) |=> (secR == 8'h00));

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkCtrl[7] && !stb.wrEn) |=> ($stable(secR) && $stable(minR) && $stable(hrR)));

  // R7
  pm_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && hrR[7] && hrR[4:0] == 5'h11 && secWrap && minWrap)
      |=> (hrR[5] != $past(hrR[5])));

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrStat && !setAlarm && !perEvent) |=> !irqOut);

  // R8
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(intCtrl[4]));

endmodule

// File: rtl/spi_rtc.sv
module spi_rtc
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick1Hz,
  input  logic spiSel,
  input  logic spiSck,
  input  logic spiMosi,
  output logic spiMiso,
  output logic irqOut
);

  rtcStrobe_t stb;
  logic [7:0] rdData;

  rtc_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .spiSel(spiSel), .spiSck(spiSck),
    .spiMosi(spiMosi), .rdData(rdData), .spiMiso(spiMiso), .stb(stb)
  );

  rtc_datapath #(.RAM_DEPTH(RAM_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .stb(stb),
    .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: tb/test_spi_rtc.sv
module test_spi_rtc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1Hz = 1'b0;
  logic spiSel = 1'b0, spiSck = 1'b0, spiMosi = 1'b0;
  logic spiMiso, irqOut;
  int   nChecks = 0, nFails = 0;

  localparam int HALF = 8;

  always #2 clk = ~clk;

  spi_rtc i_spi_rtc (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .spiSel(spiSel),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso), .irqOut(irqOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic txnBegin();
    spiSel = 1'b1;
    waitClk(HALF);
  endtask

  task automatic txnEnd();
    waitClk(HALF);
    spiSel = 1'b0;
    waitClk(HALF);
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      waitClk(HALF);
      rx[i]  = spiMiso;
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  task automatic writeReg(input logic [7:0] addr, input logic [7:0] d);
    logic [7:0] r;
    txnBegin();
    spiByte(addr, r);
    spiByte(d, r);
    txnEnd();
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [7:0] d);
    logic [7:0] r;
    txnBegin();
    spiByte(addr, r);
    spiByte(8'h00, d);
    txnEnd();
  endtask

  task automatic pulseTick();
    tick1Hz = 1'b1;
    waitClk(1);
    tick1Hz = 1'b0;
    waitClk(4);
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R11 irq after reset", {7'd0, irqOut}, 8'h00);
    chk("R1 miso idle", {7'd0, spiMiso}, 8'h00);
    readReg(8'h20, d); chk("R11 seconds", d, 8'h00);
    readReg(8'h30, d); chk("R11 status", d, 8'h00);
    readReg(8'h07, d); chk("R11 ram", d, 8'h00);
  endtask

  task automatic testRam();
    logic [7:0] d;
    logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    txnBegin();
    spiByte(8'h85, d);
    for (int i = 0; i < 4; i++) spiByte(pat[i], d);
    txnEnd();
    txnBegin();
    spiByte(8'h05, d);
    for (int i = 0; i < 4; i++) begin
      spiByte(8'h00, d);
      chk("R2 R3 ram burst", d, pat[i]);
    end
    txnEnd();
    writeReg(8'h9F, 8'h5A);
    readReg(8'h1F, d); chk("R3 ram top", d, 8'h5A);
    readReg(8'h27, d); chk("R4 unmapped read", d, 8'h00);
    readReg(8'h28, d); chk("R4 alarm not readable", d, 8'h00);
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    logic [7:0] r;
    txnBegin();
    spiByte(8'hA0, r); spiByte(s, r); spiByte(m, r); spiByte(h, r);
    txnEnd();
  endtask

  task automatic testTimeRegs();
    logic [7:0] d;
    logic [7:0] tv [7] = '{8'h58, 8'h59, 8'h23, 8'h07, 8'h15, 8'h08, 8'h99};
    txnBegin();
    spiByte(8'hA0, d);
    for (int i = 0; i < 7; i++) spiByte(tv[i], d);
    txnEnd();
    txnBegin();
    spiByte(8'h20, d);
    for (int i = 0; i < 7; i++) begin
      spiByte(8'h00, d);
      chk("R4 time burst", d, tv[i]);
    end
    txnEnd();
  endtask

  task automatic testStopStart();
    logic [7:0] d;
    pulseTick();
    readReg(8'h20, d); chk("R5 stopped tick ignored", d, 8'h58);
    writeReg(8'hB1, 8'h80);
    readReg(8'h31, d); chk("R4 clock control", d, 8'h80);
    pulseTick();
    readReg(8'h20, d); chk("R5 running tick", d, 8'h59);
    pulseTick();
    readReg(8'h20, d); chk("R6 sec wrap", d, 8'h00);
    readReg(8'h21, d); chk("R6 min wrap", d, 8'h00);
    readReg(8'h22, d); chk("R6 hour wrap", d, 8'h00);
    readReg(8'h23, d); chk("R6 day of week wrap", d, 8'h01);
  endtask

  task automatic test12Hour();
    logic [7:0] d;
    setTime(8'h59, 8'h59, 8'h91);
    pulseTick();
    readReg(8'h22, d); chk("R7 11AM to 12PM", d, 8'hB2);
    setTime(8'h59, 8'h59, 8'hB2);
    pulseTick();
    readReg(8'h22, d); chk("R7 12PM to 1PM", d, 8'hA1);
    setTime(8'h59, 8'h59, 8'hB1);
    pulseTick();
    readReg(8'h22, d); chk("R7 11PM to 12AM", d, 8'h92);
    readReg(8'h23, d); chk("R7 day advance", d, 8'h02);
  endtask

  task automatic testAlarm();
    logic [7:0] d;
    logic [7:0] r;
    txnBegin();
    spiByte(8'hA8, r); spiByte(8'h05, r); spiByte(8'h00, r); spiByte(8'h01, r);
    txnEnd();
    setTime(8'h03, 8'h00, 8'h01);
    writeReg(8'hB2, 8'h10);
    pulseTick();
    chk("R8 no early alarm", {7'd0, irqOut}, 8'h00);
    pulseTick();
    chk("R8 alarm irq", {7'd0, irqOut}, 8'h01);
    readReg(8'h30, d); chk("R10 status alarm", d, 8'h42);
    chk("R10 irq cleared", {7'd0, irqOut}, 8'h00);
    readReg(8'h30, d); chk("R10 status empty", d, 8'h00);
    writeReg(8'hB2, 8'h00);
    setTime(8'h04, 8'h00, 8'h01);
    pulseTick();
    chk("R8 disabled alarm", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testPeriodic();
    logic [7:0] d;
    writeReg(8'hB2, 8'h0C);
    pulseTick();
    chk("R9 per-second irq", {7'd0, irqOut}, 8'h01);
    readReg(8'h30, d); chk("R9 R10 status periodic", d, 8'h41);
    writeReg(8'hB2, 8'h0D);
    pulseTick();
    chk("R9 no minute event", {7'd0, irqOut}, 8'h00);
    writeReg(8'hA0, 8'h59);
    pulseTick();
    chk("R9 minute event", {7'd0, irqOut}, 8'h01);
    readReg(8'h30, d); chk("R9 status minute", d, 8'h41);
    writeReg(8'hB2, 8'h03);
    pulseTick();
    chk("R9 unused code", {7'd0, irqOut}, 8'h00);
  endtask

  initial begin
    fork
      begin
        waitClk(5);
        rstN = 1'b1;
        waitClk(5);
        testReset();
        testRam();
        testTimeRegs();
        testStopStart();
        test12Hour();
        testAlarm();
        testPeriodic();
      end
      begin
        waitClk(150000);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule